// File: doc/BRIEF.md
# Overlapped Instruction Timing Sequencer

This block is the timing generator and a minimal execution core for an 8-bit processor that supports four instructions: load-immediate into the accumulator, load-immediate into the index register, add-immediate with carry to the accumulator, and store of the accumulator to a zero-page address. Every clock cycle is one bus cycle, either a read or a write, and there are no idle cycles. The address stays valid for the whole cycle. The read/write line stays high for all of a read.

The sequencer counts an opcode fetch as the closing cycle of the instruction before it. While the new opcode is being fetched, the instruction register still holds the old opcode. The old instruction's final step happens in that same cycle: the accumulator or index load, or the write of the add result. Immediate instructions therefore take two cycles. The first is the fetch. The second is a merged decide-and-operand cycle that reads the operand byte. The store takes three cycles: fetch, address byte, then the write.

The merged cycle and the last cycle of the store are the decision points. At those points the interrupt request is sampled into a pending flag. Servicing the request is not part of this block. The accumulator, index register and carry are brought out so that their updates can be seen.

Top module: `ovl_seq_core`

## Requirements
- R1: Each cycle is one bus transfer. `rw_o` is 1 for a read and 0 for a write. The only write cycle is the last cycle of a store, and every other cycle is a read.
- R2: `sync_o` is 1 only in an opcode fetch cycle. In that cycle `addr_o` equals the program counter. After reset the first fetch is from `RESET_PC` (default 0x0200).
- R3: Opcodes 0xA9 (load accumulator), 0xA2 (load index) and 0x69 (add) each take two cycles: the fetch, then one operand read at the next address. The program counter advances after the opcode fetch and again after the operand fetch, so the next fetch is at opcode address + 2.
- R4: For 0xA9 and 0xA2 the loaded value appears on `acc_o` or `xreg_o` in the cycle after the next opcode fetch, not earlier.
- R5: 0x69 adds the operand and the carry to the accumulator in binary. The 8-bit sum reaches `acc_o` and the carry-out reaches `carry_o` in the cycle after the next opcode fetch.
- R6: Opcode 0x85 takes three cycles: the fetch, a read of the address byte at the next address, then a write of the accumulator to address {0x00, address byte}. The next fetch is at opcode address + 2.
- R7: `irq_i` is sampled only in the merged operand cycle and in the store's write cycle. The result appears on `irq_flag_o` in the following cycle and holds until the next sampling cycle.
- R8: Any other opcode is a two-cycle no-operation. Its second cycle reads opcode address + 1 without advancing the program counter, so the next fetch is at opcode address + 1. No register changes.
- R9: While `rst_n` is low, `acc_o`, `xreg_o`, `carry_o` and `irq_flag_o` are 0, and the block presents an opcode fetch (`sync_o`=1, `rw_o`=1) at `RESET_PC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_o | output | AW | Bus address, valid for the whole cycle |
| rdata_i | input | DW | Read data, sampled at the end of a read cycle |
| wdata_o | output | DW | Write data, the accumulator during a write cycle |
| rw_o | output | 1 | 1 = read cycle, 0 = write cycle |
| sync_o | output | 1 | High during an opcode fetch cycle |
| irq_i | input | 1 | Interrupt request level |
| irq_flag_o | output | 1 | Request seen at the last decision cycle |
| acc_o | output | DW | Accumulator value |
| xreg_o | output | DW | Index register value |
| carry_o | output | 1 | Carry flag |

## Verification
The bus outputs (address, read/write line, write data, sync) are combinational from state that is registered at the edge that ends the previous cycle. The bench therefore compares them in the middle of the cycle it expects them in. Register results arrive one cycle later than a non-overlapped design would deliver them. A load or add result is due in the cycle after the next opcode fetch, which is two cycles after its operand read. The bench checks that the old value is still there in the fetch cycle and that the new value is present one cycle later. The interrupt flag is due one cycle after a decision cycle and must not move after fetch or address-byte cycles. The add is swept over 256 operand pairs with chained carry, and each sum is read back from zero-page memory once the store's write cycle has passed.

// File: rtl/ovl_seq_pkg.sv
package ovl_seq_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,   // opcode fetch, closes previous instruction
        ST_MERGE = 2'd1,   // decide + operand read, two-cycle ops
        ST_ADDR  = 2'd2,   // zero-page address byte read
        ST_DECIDE = 2'd3   // decide cycle, store write
    } tstate_e;

    typedef enum logic [2:0] {
        K_NOP = 3'd0,
        K_LDA = 3'd1,
        K_LDX = 3'd2,
        K_ADC = 3'd3,
        K_STA = 3'd4
    } opkind_e;

    localparam logic [7:0] OPC_LDA = 8'hA9;
    localparam logic [7:0] OPC_LDX = 8'hA2;
    localparam logic [7:0] OPC_ADC = 8'h69;
    localparam logic [7:0] OPC_STA = 8'h85;
    localparam logic [7:0] OPC_NOP = 8'hEA;

endpackage

// File: rtl/ovl_seq_decode.sv
module ovl_seq_decode
    import ovl_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] op_i,
    output opkind_e       kind_o
);

    always_comb begin
        kind_o = K_NOP;
        if (op_i == DW'(OPC_LDA))      kind_o = K_LDA;
        else if (op_i == DW'(OPC_LDX)) kind_o = K_LDX;
        else if (op_i == DW'(OPC_ADC)) kind_o = K_ADC;
        else if (op_i == DW'(OPC_STA)) kind_o = K_STA;
    end

endmodule

// File: rtl/ovl_seq_adder.sv
module ovl_seq_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          c_i,
    output logic [DW:0]   sum_o
);

    always_comb begin
        sum_o = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, c_i};
    end

endmodule

// File: rtl/ovl_seq_busmux.sv
module ovl_seq_busmux
    import ovl_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  tstate_e       st_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] zp_i,
    input  logic [DW-1:0] acc_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          rw_o,
    output logic          sync_o
);

    localparam int HI_W = AW - DW;

    always_comb begin
        addr_o  = pc_i;
        wdata_o = '0;
        rw_o    = 1'b1;
        sync_o  = (st_i == ST_FETCH);
        if (st_i == ST_DECIDE) begin
            addr_o  = {{HI_W{1'b0}}, zp_i};
            wdata_o = acc_i;
            rw_o    = 1'b0;
        end
    end

endmodule

// File: rtl/ovl_seq_core.sv
module ovl_seq_core
    import ovl_seq_pkg::*;
#(
    parameter int              AW       = 16,
    parameter int              DW       = 8,
    parameter logic [AW-1:0]   RESET_PC = 16'h0200
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] addr_o,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] wdata_o,
    output logic          rw_o,
    output logic          sync_o,
    input  logic          irq_i,
    output logic          irq_flag_o,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] xreg_o,
    output logic          carry_o
);

    typedef struct packed {
        tstate_e       st;
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] opnd;
        logic [DW:0]   sum;
        logic [DW-1:0] zp;
        logic [DW-1:0] acc;
        logic [DW-1:0] xr;
        logic          cy;
        logic          irqf;
    } regs_t;

    regs_t   r_q, r_d;
    opkind_e cur_kind;   // instruction held in ir (the one being closed/run)
    opkind_e new_kind;   // opcode arriving on the bus in a fetch cycle
    logic [DW:0] add_res;

    ovl_seq_decode #(.DW(DW)) u_dec_cur (.op_i(r_q.ir),  .kind_o(cur_kind));
    ovl_seq_decode #(.DW(DW)) u_dec_new (.op_i(rdata_i), .kind_o(new_kind));

    ovl_seq_adder #(.DW(DW)) u_add (
        .a_i   (r_q.acc),
        .b_i   (rdata_i),
        .c_i   (r_q.cy),
        .sum_o (add_res)
    );

    ovl_seq_busmux #(.AW(AW), .DW(DW)) u_bus (
        .st_i    (r_q.st),
        .pc_i    (r_q.pc),
        .zp_i    (r_q.zp),
        .acc_i   (r_q.acc),
        .addr_o  (addr_o),
        .wdata_o (wdata_o),
        .rw_o    (rw_o),
        .sync_o  (sync_o)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_FETCH: begin
                // close the previous instruction while fetching the next
                unique case (cur_kind)
                    K_LDA: r_d.acc = r_q.opnd;
                    K_LDX: r_d.xr  = r_q.opnd;
                    K_ADC: begin
                        r_d.acc = r_q.sum[DW-1:0];
                        r_d.cy  = r_q.sum[DW];
                    end
                    default: ;
                endcase
                r_d.ir = rdata_i;
                r_d.pc = r_q.pc + 1'b1;
                r_d.st = (new_kind == K_STA) ? ST_ADDR : ST_MERGE;
            end
            ST_MERGE: begin
                r_d.irqf = irq_i;
                r_d.opnd = rdata_i;
                r_d.sum  = add_res;
                if (cur_kind != K_NOP) r_d.pc = r_q.pc + 1'b1;
                r_d.st = ST_FETCH;
            end
            ST_ADDR: begin
                r_d.zp = rdata_i;
                r_d.pc = r_q.pc + 1'b1;
                r_d.st = ST_DECIDE;
            end
            ST_DECIDE: begin
                r_d.irqf = irq_i;
                r_d.st   = ST_FETCH;
            end
            default: r_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_FETCH;
            r_q.pc   <= RESET_PC;
            r_q.ir   <= DW'(OPC_NOP);
            r_q.opnd <= '0;
            r_q.sum  <= '0;
            r_q.zp   <= '0;
            r_q.acc  <= '0;
            r_q.xr   <= '0;
            r_q.cy   <= 1'b0;
            r_q.irqf <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_flag_o = r_q.irqf;
    assign acc_o      = r_q.acc;
    assign xreg_o     = r_q.xr;
    assign carry_o    = r_q.cy;

endmodule

// File: rtl/ovl_seq_core_chk.sv
module ovl_seq_core_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_o,
    input logic          rw_o,
    input logic          sync_o,
    input logic          irq_flag_o,
    input logic [DW-1:0] acc_o,
    input logic [DW-1:0] xreg_o,
    input logic          carry_o
);

    AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> rw_o); // R2

    AST_WRITE_IN_ZERO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_o |-> (addr_o[AW-1:DW] == '0)); // R6

    AST_WRITE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_o |=> sync_o); // R1

    AST_AFTER_FETCH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> (rw_o && !sync_o)); // R3

    AST_ACC_ONLY_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_o |=> ($stable(acc_o) && $stable(carry_o))); // R5

    AST_XREG_ONLY_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_o |=> $stable(xreg_o)); // R4

    AST_FLAG_HELD_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> $stable(irq_flag_o)); // R7

endmodule

bind ovl_seq_core ovl_seq_core_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_o     (addr_o),
    .rw_o       (rw_o),
    .sync_o     (sync_o),
    .irq_flag_o (irq_flag_o),
    .acc_o      (acc_o),
    .xreg_o     (xreg_o),
    .carry_o    (carry_o)
);

// File: tb/test_ovl_seq_core.sv
module test_ovl_seq_core;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int WATCHDOG = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic [DW-1:0] rdata;
    logic [DW-1:0] wdata;
    logic          rw;
    logic          sync;
    logic          irq = 1'b0;
    logic          irq_flag;
    logic [DW-1:0] acc;
    logic [DW-1:0] xreg;
    logic          carry;

    logic [7:0] mem [0:1023];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rdata = mem[addr[9:0]];

    ovl_seq_core #(.AW(AW), .DW(DW), .RESET_PC(16'h0200)) i_ovl_seq_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_o     (addr),
        .rdata_i    (rdata),
        .wdata_o    (wdata),
        .rw_o       (rw),
        .sync_o     (sync),
        .irq_i      (irq),
        .irq_flag_o (irq_flag),
        .acc_o      (acc),
        .xreg_o     (xreg),
        .carry_o    (carry)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // complete one bus cycle: memory takes a write, then move to mid next cycle
    task automatic step();
        if (rst_n && !rw) mem[addr[9:0]] = wdata;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'hEA;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 acc in reset", acc, 0);
        chk("R9 xreg in reset", xreg, 0);
        chk("R9 carry in reset", carry, 0);
        chk("R9 irq flag in reset", irq_flag, 0);
        chk("R9 sync in reset", sync, 1);
        chk("R9 rw in reset", rw, 1);
        chk("R9 addr in reset", addr, 16'h0200);
        rst_n = 1'b1;   // now mid cycle 0
    endtask

    initial begin
        int seed_c;
        logic [8:0] s;
        logic [7:0] exp_zp [0:15];
        @(negedge clk);

        // ---------------- directed overlapped trace ----------------
        fill_mem();
        mem[10'h200] = 8'hA2; mem[10'h201] = 8'h11;
        mem[10'h202] = 8'hA9; mem[10'h203] = 8'h22;
        mem[10'h204] = 8'h69; mem[10'h205] = 8'h33;
        mem[10'h206] = 8'h85; mem[10'h207] = 8'h40;
        mem[10'h208] = 8'hFF; mem[10'h209] = 8'hEA;
        do_reset();
        // cycle 0
        chk("R2 first fetch addr", addr, 16'h0200);
        chk("R2 first fetch sync", sync, 1);
        chk("R1 fetch is read", rw, 1);
        step(); // cycle 1
        chk("R3 operand addr", addr, 16'h0201);
        chk("R3 operand sync low", sync, 0);
        chk("R1 operand is read", rw, 1);
        step(); // cycle 2
        chk("R3 next fetch at +2", addr, 16'h0202);
        chk("R3 next fetch sync", sync, 1);
        chk("R4 xreg not yet loaded", xreg, 0);
        step(); // cycle 3
        chk("R4 xreg loaded after fetch", xreg, 8'h11);
        chk("R3 operand addr", addr, 16'h0203);
        step(); // cycle 4
        chk("R4 acc not yet loaded", acc, 0);
        chk("R2 fetch addr", addr, 16'h0204);
        step(); // cycle 5
        chk("R4 acc loaded after fetch", acc, 8'h22);
        step(); // cycle 6: fetch of store
        chk("R5 sum not yet written", acc, 8'h22);
        chk("R2 store fetch sync", sync, 1);
        irq = 1'b1;
        step(); // cycle 7: address byte
        chk("R5 sum written", acc, 8'h55);
        chk("R5 carry out zero", carry, 0);
        chk("R6 address byte addr", addr, 16'h0207);
        chk("R6 address byte read", rw, 1);
        chk("R7 flag not sampled in fetch", irq_flag, 0);
        step(); // cycle 8: write
        chk("R6 write addr", addr, 16'h0040);
        chk("R1 write cycle rw", rw, 0);
        chk("R6 write data", wdata, 8'h55);
        chk("R7 flag not sampled in addr cycle", irq_flag, 0);
        step(); // cycle 9: fetch 0xFF
        chk("R7 flag set after decide", irq_flag, 1);
        chk("R6 fetch after store at +2", addr, 16'h0208);
        chk("R6 fetch sync after store", sync, 1);
        irq = 1'b0;
        step(); // cycle 10: no-op second cycle
        chk("R8 no-op reads next byte", addr, 16'h0209);
        chk("R8 no-op read", rw, 1);
        chk("R7 flag held", irq_flag, 1);
        step(); // cycle 11
        chk("R8 no-op fetch at +1", addr, 16'h0209);
        chk("R8 no-op fetch sync", sync, 1);
        chk("R7 flag cleared after merged decide", irq_flag, 0);
        chk("R8 acc unchanged", acc, 8'h55);
        chk("R8 xreg unchanged", xreg, 8'h11);
        chk("R6 stored byte", mem[10'h040], 8'h55);

        // ---------------- add sweep with chained carry ----------------
        for (int b = 0; b < 16; b++) begin
            fill_mem();
            seed_c = 0;
            for (int j = 0; j < 16; j++) begin
                int n;
                logic [7:0] av, bv;
                n = b * 16 + j;
                av = 8'((n * 29 + 3) & 255);
                bv = 8'((n * 71 + b) & 255);
                mem[10'h200 + 6*j + 0] = 8'hA9;
                mem[10'h200 + 6*j + 1] = av;
                mem[10'h200 + 6*j + 2] = 8'h69;
                mem[10'h200 + 6*j + 3] = bv;
                mem[10'h200 + 6*j + 4] = 8'h85;
                mem[10'h200 + 6*j + 5] = 8'(8'h10 + j);
                s = 9'(av) + 9'(bv) + 9'(seed_c);
                exp_zp[j] = s[7:0];
                seed_c = int'(s[8]);
            end
            do_reset();
            repeat (120) step();
            for (int j = 0; j < 16; j++)
                chk("R5 swept sum in zero page", mem[10'h010 + j], exp_zp[j]);
            chk("R5 final acc", acc, exp_zp[15]);
            chk("R5 final carry", carry, seed_c);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule